// File: doc/BRIEF.md
# DMA Interrupt Status and Mask Unit

This unit gathers the event pulses raised by a transmit DMA engine and a receive DMA engine and turns them into one level-sensitive interrupt line. Each engine owns a small sticky status register. A one-cycle event pulse sets its bit, and the bit stays set until software clears it by writing a 1 to that bit. No read-modify-write is needed to acknowledge an event.

A combined cause register gives software a live view of all six engine status bits at fixed positions. A mask register chooses which of those bits may raise the interrupt. The interrupt output is high while any cause bit is set together with its mask bit. A typical driver enables receive, receive overflow and both bus errors, and leaves transmit done and transmit underrun masked.

Register access uses a plain single-cycle write strobe and a combinational read data path decoded from the address.

Top module: `dma_irq_unit`

## Requirements
- R1: After reset (synchronous, active low), all status and mask registers read zero and `irq_o` is low.
- R2: Transmit events `tx_evt_i` are encoded {bus error, underrun, done} in bits [2:0]. A pulse sets the transmit status register (offset 0x188) at bit 3 for bus error, bit 1 for underrun and bit 0 for done. Each bit stays set until it is cleared.
- R3: Receive events `rx_evt_i` are encoded {bus error, overflow, packet} in bits [2:0]. A pulse sets the receive status register (offset 0x194) at bit 3 for bus error, bit 2 for overflow and bit 0 for packet. Each bit stays set until it is cleared.
- R4: The cause register (offset 0x19C) reads the live engine bits in the same cycle, with no latch of its own. The positions are: bit 0 transmit done, bit 1 transmit underrun, bit 3 transmit bus error, bit 4 receive packet, bit 6 receive overflow, bit 7 receive bus error. Bits 2, 5 and 8 to 31 read zero.
- R5: Writing an engine status register clears exactly the bits written as 1. Bits written as 0 are left unchanged.
- R6: An event in the same cycle as a clear of its bit leaves the bit set.
- R7: The mask register (offset 0x198) stores only bits 0, 1, 3, 4, 6 and 7 and reads back zero elsewhere.
- R8: `irq_o` is high exactly when some cause bit and its mask bit are both set. A mask write changes `irq_o` from the next clock cycle on, and not before the clock edge.
- R9: Writes to the cause register are ignored.
- R10: Writing a 1 to an engine status bit position that holds no event (for example transmit bit 2) has no effect. Such a bit reads zero. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_evt_i | input | 3 | Transmit event pulses {bus error, underrun, done} |
| rx_evt_i | input | 3 | Receive event pulses {bus error, overflow, packet} |
| reg_addr_i | input | ADDR_W (9) | Register byte offset |
| reg_wr_i | input | 1 | Write strobe, one cycle per write |
| reg_wdata_i | input | DATA_W (32) | Write data |
| reg_rdata_o | output | DATA_W (32) | Combinational read data for `reg_addr_i` |
| irq_o | output | 1 | Interrupt request, level |

## Verification
An event pulse, a write-1-to-clear and a mask write all take effect at the rising edge that samples them. The changed value therefore shows on `irq_o` and on read data just after that same edge. A read itself adds no cycle, because read data follows the address combinationally. The bench drives every stimulus on the falling edge and samples 1 ns after the following rising edge, with the read address already set up. For the mask-timing case it also samples `irq_o` before that edge, to show the old value still holds.

// File: rtl/dmairq_pkg.sv
// Package: shared constants of the DMA interrupt unit.
// Offsets, per-engine implemented-bit masks and the map from the six
// event sources to engine status bits and cause register bits.
package dmairq_pkg;
    localparam int REG_W   = 32;
    localparam int OFF_W   = 9;
    localparam int N_ENG   = 2;           // 0 = transmit, 1 = receive
    localparam int EVT_PER = 3;           // events per engine
    localparam int NSRC    = N_ENG * EVT_PER;

    localparam int OFF_TX_STAT = 'h188;
    localparam int OFF_RX_STAT = 'h194;
    localparam int OFF_MASK    = 'h198;
    localparam int OFF_CAUSE   = 'h19C;

    localparam int ENG_OFF [N_ENG] = '{OFF_TX_STAT, OFF_RX_STAT};
    localparam logic [REG_W-1:0] ENG_IMPL [N_ENG] = '{32'h0000_000B, 32'h0000_000D};
    localparam logic [REG_W-1:0] CAUSE_IMPL = 32'h0000_00DB;

    // Source k: 0 tx done, 1 tx underrun, 2 tx bus error,
    //           3 rx packet, 4 rx overflow, 5 rx bus error
    localparam int SRC_ENG [NSRC] = '{0, 0, 0, 1, 1, 1};
    localparam int SRC_BIT [NSRC] = '{0, 1, 3, 0, 2, 3};
    localparam int SRC_POS [NSRC] = '{0, 1, 3, 4, 6, 7};
endpackage

// File: rtl/dmairq_evbank.sv
// Module: sticky event bank of one DMA engine.
// Event pulses set bits and written ones clear them; a set wins over a
// clear in the same cycle. Only bits in IMPL can ever hold a one.
// Assumes set and clear vectors already sit in register bit positions.
module dmairq_evbank #(
    parameter int               W    = 32,
    parameter logic [W-1:0]     IMPL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q;

    // Purpose: hold sticky bits, set has priority over write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= ((q | set_i) & ~(clr_i & ~set_i)) & IMPL;
        end
    end

    assign q_o = q;

    // R2 / R3: with no event and no clear the bank keeps its value
    p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i | clr_i) == '0) |=> $stable(q_o));

    // R6: an implemented bit with an event is set next cycle, clear or not
    p_setwins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i & IMPL) != '0) |=> ((q_o & $past(set_i & IMPL)) == $past(set_i & IMPL)));

    // R5: a cleared bit without a concurrent event reads zero next cycle
    p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_i & ~set_i) != '0) |=> ((q_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/dmairq_map.sv
// Module: builds the combined cause word from the six live source levels.
// Purely combinational; unused positions are driven zero.
module dmairq_map
    import dmairq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_i,
    output logic [W-1:0]    cause_o
);
    // Purpose: scatter each source level to its cause bit position.
    always_comb begin
        cause_o = '0;
        for (int k = 0; k < NSRC; k++) begin
            cause_o[SRC_POS[k]] = src_i[k];
        end
    end

    // R4: the cause word carries exactly the set source levels, nothing else
    p_map_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cause_o) == $countones(src_i));
endmodule

// File: rtl/dmairq_mask.sv
// Module: interrupt mask register and request output.
// Stores only implemented bits; the request is the OR of cause AND mask.
// Assumes cause_i is already zero in unimplemented positions.
module dmairq_mask #(
    parameter int           W    = 32,
    parameter logic [W-1:0] IMPL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en_i,
    input  logic [W-1:0] wdata_i,
    input  logic [W-1:0] cause_i,
    output logic [W-1:0] mask_o,
    output logic         irq_o
);
    logic [W-1:0] mask_q;

    // Purpose: capture the mask on a write to its offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (wr_en_i) begin
            mask_q <= wdata_i & IMPL;
        end
    end

    assign mask_o = mask_q;
    assign irq_o  = |(cause_i & mask_q);

    // R8: writing an all-zero mask drops the request on the next cycle
    p_maskoff_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && ((wdata_i & IMPL) == '0)) |=> !irq_o);
endmodule

// File: rtl/dmairq_rdmux.sv
// Module: read data decoder of the unit.
// Combinational: selects a register by byte offset; unmapped reads give 0.
module dmairq_rdmux
    import dmairq_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 9
) (
    input  logic [AW-1:0] addr_i,
    input  logic [W-1:0]  tx_q_i,
    input  logic [W-1:0]  rx_q_i,
    input  logic [W-1:0]  mask_i,
    input  logic [W-1:0]  cause_i,
    output logic [W-1:0]  rdata_o
);
    // Purpose: pick the addressed register.
    always_comb begin
        if (addr_i == AW'(OFF_TX_STAT))      rdata_o = tx_q_i;
        else if (addr_i == AW'(OFF_RX_STAT)) rdata_o = rx_q_i;
        else if (addr_i == AW'(OFF_MASK))    rdata_o = mask_i;
        else if (addr_i == AW'(OFF_CAUSE))   rdata_o = cause_i;
        else                                 rdata_o = '0;
    end
endmodule

// File: rtl/dma_irq_unit.sv
// Module: top of the DMA interrupt status and mask unit.
// One sticky bank per engine, a live cause word, a mask and one request.
// Assumes single-cycle write strobes and event pulses in the clk domain.
module dma_irq_unit
    import dmairq_pkg::*;
#(
    parameter int DATA_W = REG_W,
    parameter int ADDR_W = OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [EVT_PER-1:0] tx_evt_i,
    input  logic [EVT_PER-1:0] rx_evt_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic               reg_wr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic               irq_o
);
    logic [NSRC-1:0]              src_evt;
    logic [NSRC-1:0]              src_lvl;
    logic [N_ENG-1:0][DATA_W-1:0] eng_q;
    logic [DATA_W-1:0]            cause;
    logic [DATA_W-1:0]            mask;
    logic                         mask_wr;

    assign src_evt = {rx_evt_i, tx_evt_i};
    assign mask_wr = reg_wr_i && (reg_addr_i == ADDR_W'(OFF_MASK));

    for (genvar e = 0; e < N_ENG; e++) begin : g_eng
        logic [DATA_W-1:0] set_v;
        logic [DATA_W-1:0] clr_v;

        // Purpose: place this engine's event pulses at their status bits.
        always_comb begin
            set_v = '0;
            for (int k = 0; k < NSRC; k++) begin
                if (SRC_ENG[k] == e) set_v[SRC_BIT[k]] = src_evt[k];
            end
        end

        assign clr_v = (reg_wr_i && (reg_addr_i == ADDR_W'(ENG_OFF[e])))
                       ? reg_wdata_i : '0;

        dmairq_evbank #(.W(DATA_W), .IMPL(DATA_W'(ENG_IMPL[e]))) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_v),
            .clr_i (clr_v),
            .q_o   (eng_q[e])
        );
    end

    // Purpose: gather the live status bit of each source.
    always_comb begin
        for (int k = 0; k < NSRC; k++) begin
            src_lvl[k] = eng_q[SRC_ENG[k]][SRC_BIT[k]];
        end
    end

    dmairq_map #(.W(DATA_W)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_i   (src_lvl),
        .cause_o (cause)
    );

    dmairq_mask #(.W(DATA_W), .IMPL(DATA_W'(CAUSE_IMPL))) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (mask_wr),
        .wdata_i (reg_wdata_i),
        .cause_i (cause),
        .mask_o  (mask),
        .irq_o   (irq_o)
    );

    dmairq_rdmux #(.W(DATA_W), .AW(ADDR_W)) u_rd (
        .addr_i  (reg_addr_i),
        .tx_q_i  (eng_q[0]),
        .rx_q_i  (eng_q[1]),
        .mask_i  (mask),
        .cause_i (cause),
        .rdata_o (reg_rdata_o)
    );

    // R9: a cause write with no event leaves the cause word unchanged
    p_cause_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && (reg_addr_i == ADDR_W'(OFF_CAUSE)) && (src_evt == '0)
         && !(reg_addr_i == ADDR_W'(OFF_TX_STAT)) && !(reg_addr_i == ADDR_W'(OFF_RX_STAT)))
        |=> $stable(cause));
endmodule

// File: tb/dma_irq_unit_test.sv
module dma_irq_unit_test;
    localparam int CLK_P = 10;
    localparam logic [8:0] A_TX = 9'h188, A_RX = 9'h194, A_MASK = 9'h198, A_CAUSE = 9'h19C;

    // Entry: {tx_evt[3], rx_evt[3], wr, sel[2] (0 mask,1 cause,2 tx,3 rx), wdata[8], exp_cause[8], exp_irq}
    localparam int NV = 18;
    localparam logic [25:0] VEC [NV] = '{
        {3'b001, 3'b000, 1'b0, 2'd0, 8'h00, 8'h01, 1'b0}, // R2 tx done latched, masked
        {3'b000, 3'b000, 1'b1, 2'd0, 8'hD8, 8'h01, 1'b0}, // R8 default mask, done still masked
        {3'b000, 3'b001, 1'b0, 2'd0, 8'h00, 8'h11, 1'b1}, // R3 rx packet raises irq
        {3'b000, 3'b000, 1'b1, 2'd3, 8'h01, 8'h01, 1'b0}, // R5 clear rx packet
        {3'b010, 3'b000, 1'b0, 2'd0, 8'h00, 8'h03, 1'b0}, // R4 tx underrun at bit 1
        {3'b000, 3'b010, 1'b0, 2'd0, 8'h00, 8'h43, 1'b1}, // R4 rx overflow at bit 6
        {3'b000, 3'b010, 1'b1, 2'd3, 8'h04, 8'h43, 1'b1}, // R6 set wins over clear
        {3'b000, 3'b000, 1'b1, 2'd3, 8'h04, 8'h03, 1'b0}, // R5 clear overflow
        {3'b000, 3'b000, 1'b1, 2'd0, 8'hFF, 8'h03, 1'b1}, // R8 unmask all
        {3'b000, 3'b000, 1'b1, 2'd2, 8'h03, 8'h00, 1'b0}, // R5 clear two tx bits
        {3'b100, 3'b100, 1'b0, 2'd0, 8'h00, 8'h88, 1'b1}, // R4 both bus errors
        {3'b000, 3'b000, 1'b1, 2'd1, 8'hFF, 8'h88, 1'b1}, // R9 cause write ignored
        {3'b000, 3'b000, 1'b1, 2'd2, 8'h08, 8'h80, 1'b1}, // R5 only tx bus error cleared
        {3'b000, 3'b000, 1'b1, 2'd0, 8'h00, 8'h80, 1'b0}, // R8 mask off
        {3'b000, 3'b000, 1'b1, 2'd3, 8'h08, 8'h00, 1'b0}, // R5 clear rx bus error
        {3'b111, 3'b111, 1'b0, 2'd0, 8'h00, 8'hDB, 1'b0}, // R4 all six sources
        {3'b000, 3'b000, 1'b1, 2'd2, 8'h04, 8'hDB, 1'b0}, // R10 unused tx bit write
        {3'b000, 3'b000, 1'b1, 2'd0, 8'h02, 8'hDB, 1'b1}  // R8 underrun alone unmasked
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  tx_evt = '0, rx_evt = '0;
    logic [8:0]  addr = '0;
    logic        wr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    dma_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .tx_evt_i(tx_evt), .rx_evt_i(rx_evt),
        .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [8:0] sel_addr(input logic [1:0] s);
        case (s)
            2'd0: sel_addr = A_MASK;
            2'd1: sel_addr = A_CAUSE;
            2'd2: sel_addr = A_TX;
            default: sel_addr = A_RX;
        endcase
    endfunction

    // One clock: drive at falling edge, settle after rising edge, then idle.
    task automatic step(input logic [2:0] t, input logic [2:0] r, input logic w,
                        input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        tx_evt = t; rx_evt = r; wr = w; addr = a; wdata = d;
        @(posedge clk);
        #1;
        tx_evt = '0; rx_evt = '0; wr = 1'b0;
    endtask

    task automatic read_chk(input string req, input logic [8:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        check(req, rdata, exp);
    endtask

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        read_chk("R1 cause", A_CAUSE, 32'h0);
        read_chk("R1 mask", A_MASK, 32'h0);
        read_chk("R1 tx", A_TX, 32'h0);
        read_chk("R1 rx", A_RX, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [25:0] v;
            v = VEC[i];
            step(v[25:23], v[22:20], v[19], sel_addr(v[18:17]), {24'h0, v[16:9]});
            read_chk($sformatf("R4 vector %0d cause", i), A_CAUSE, {24'h0, v[8:1]});
            check($sformatf("R8 vector %0d irq", i), {31'h0, irq}, {31'h0, v[0]});
        end

        // R2 / R3 / R10 engine readback after all events and the unused-bit write
        read_chk("R2 tx status", A_TX, 32'h0000_000B);
        read_chk("R3 rx status", A_RX, 32'h0000_000D);
        read_chk("R10 unmapped read", 9'h000, 32'h0);

        // R7 mask keeps only implemented bits
        step(3'b000, 3'b000, 1'b1, A_MASK, 32'hFFFF_FFFF);
        read_chk("R7 mask readback", A_MASK, 32'h0000_00DB);
        check("R8 irq all unmasked", {31'h0, irq}, 32'h1);

        // R8 mask write not visible before the edge, visible after it
        @(negedge clk);
        wr = 1'b1; addr = A_MASK; wdata = 32'h0;
        #1;
        check("R8 irq before edge", {31'h0, irq}, 32'h1);
        @(posedge clk);
        #1;
        wr = 1'b0;
        check("R8 irq after edge", {31'h0, irq}, 32'h0);

        // R1 reset in mid-run clears everything
        step(3'b000, 3'b000, 1'b1, A_MASK, 32'h0000_00FF);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        read_chk("R1 cause after reset", A_CAUSE, 32'h0);
        read_chk("R1 mask after reset", A_MASK, 32'h0);
        check("R1 irq after reset", {31'h0, irq}, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule